// File: doc/BRIEF.md
# Adaptive Dead-Time Half-Bridge Sequencer

This block sequences the two gate-enable outputs of one synchronous buck phase from a single PWM command. The high-side enable tracks the command and the low-side enable tracks its complement. Neither switch is released until the other one is sensed as off. The block gets three clean logic sense levels from outside comparators: the low-side gate is below threshold, the switch node is below threshold, and the high-side gate is discharged. After the relevant sense asserts, a short settling delay follows before the opposite switch turns on.

The switch node may never fall, for example while the phase sinks current. For that case a fixed fallback timer starts once the high-side gate is seen discharged. When it expires, the low side is turned on anyway, so the bootstrap supply gets recharged every cycle. A driver-enable input and an undervoltage-lockout input both force the phase off. An active-low skip input keeps the low side off for light-load operation, while the high side still follows PWM.

Every input passes through a two-flop synchroniser. A change that settles before a rising edge is therefore seen by the sequencer after the second edge and moves its state on the third. All delays are parameters in nanoseconds and are rounded up to whole clock cycles. At the defaults (50 MHz, 40 ns, 60 ns, 250 ns) they come to 2, 3 and 13 cycles. Elaboration fails if the fallback count is not larger than the low-side delay count.

Top module: `hb_deadtime_ctrl`

## Requirements
- R1: The high-side enable is never high unless the synchronised PWM was high on the previous edge. It falls on the third rising edge after PWM falls.
- R2: The low-side enable is never high unless the synchronised PWM was low on the previous edge. With skip high and a sense condition met, PWM low drives it high.
- R3: While the enable input is low, and during reset, both gate enables are low.
- R4: While the lockout input is high, both enables are low. On release with PWM low and skip high, the low side turns on directly. Otherwise the phase passes through the both-off state and then resumes normal sequencing.
- R5: While the active-low skip input is low, the low-side enable stays low and the high side still follows PWM.
- R6: On a PWM rise, the low side turns off first, three edges after the change. The high side turns on exactly 3 + HS_CYC edges after the low-gate-low sense rises (default 5).
- R7: On a PWM fall, the high side turns off first. The low side turns on exactly 3 + LS_CYC edges after the switch-node-low sense rises (default 6).
- R8: Once the high-gate-discharged sense is high while the low-side turn-on is pending, the low side turns on exactly 2 + FB_CYC edges after that sense rose (default 15), even if the switch-node sense never rises.
- R9: A PWM reversal during a dead-time wait abandons the pending turn-on. The opposite sequence then starts from both-off, with its own sense wait and delay.
- R10: The two enables are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pwm_i | input | 1 | PWM command; high requests the high side |
| drv_en_i | input | 1 | Driver enable; low forces both switches off |
| uvlo_i | input | 1 | Supply lockout; high forces both switches off |
| skip_n_i | input | 1 | Active-low skip; low keeps the low side off |
| ls_gate_low_i | input | 1 | Sense: low-side gate below threshold |
| sw_low_i | input | 1 | Sense: switch node below threshold |
| hs_gate_off_i | input | 1 | Sense: high-side gate discharged |
| hs_en_o | output | 1 | High-side gate enable |
| ls_en_o | output | 1 | Low-side gate enable |

## Verification
The bench holds the low-gate sense low after a PWM rise. A design that released the high side on its own timer would turn it on while the low gate is still high. The bench also keeps the switch-node sense low with the high gate discharged. A design without the fallback would leave the phase off for good, and one that counted from the wrong point would miss the exact edge. PWM is reversed in the middle of a sense wait, which catches a design that finishes the stale turn-on. Lockout and enable releases are applied at both PWM levels, which exposes a wrong restart state.

// File: rtl/hbdt_pkg.sv
package hbdt_pkg;

  typedef enum logic [2:0] {
    ST_OFF     = 3'd0,
    ST_IDLE    = 3'd1,
    ST_LS_ON   = 3'd2,
    ST_HS_WAIT = 3'd3,
    ST_HS_DLY  = 3'd4,
    ST_HS_ON   = 3'd5,
    ST_LS_WAIT = 3'd6,
    ST_LS_DLY  = 3'd7
  } hb_state_e;

  // Round a nanosecond interval up to whole clock periods, never below one.
  function automatic int unsigned ns_to_cycles(input longint unsigned clk_hz,
                                               input longint unsigned ns);
    longint unsigned c;
    c = (ns * clk_hz + 64'd999_999_999) / 64'd1_000_000_000;
    return (c == 64'd0) ? 32'd1 : 32'(c);
  endfunction

endpackage

// File: rtl/hbdt_sync.sv
module hbdt_sync #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/hbdt_timer.sv
module hbdt_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] limit,
  output logic             expired
);
  logic [CNT_W-1:0] cnt;
  logic             cnt_en;

  assign expired = run && (cnt == limit - 1'b1);
  assign cnt_en  = run && !expired;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!run) begin
      cnt <= '0;
    end else if (cnt_en) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/hbdt_fsm.sv
module hbdt_fsm
  import hbdt_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      pwm_s,
  input  logic      en_s,
  input  logic      uvlo_s,
  input  logic      skip_s,
  input  logic      ls_low_s,
  input  logic      sw_low_s,
  input  logic      dly_exp,
  input  logic      fb_exp,
  output hb_state_e st,
  output logic      hs_en,
  output logic      ls_en
);
  hb_state_e nxt;
  hb_state_e low_path;

  // Where a falling PWM leads: toward the low side, or both-off under skip.
  assign low_path = skip_s ? ST_LS_WAIT : ST_IDLE;

  always_comb begin
    nxt = st;
    if (!en_s || uvlo_s) begin
      nxt = ST_OFF;
    end else begin
      unique case (st)
        ST_OFF:     nxt = (!pwm_s && skip_s) ? ST_LS_ON : ST_IDLE;
        ST_IDLE: begin
          if (pwm_s)       nxt = ST_HS_WAIT;
          else if (skip_s) nxt = ST_LS_WAIT;
        end
        ST_LS_ON: begin
          if (pwm_s)        nxt = ST_HS_WAIT;
          else if (!skip_s) nxt = ST_IDLE;
        end
        ST_HS_WAIT: begin
          if (!pwm_s)        nxt = low_path;
          else if (ls_low_s) nxt = ST_HS_DLY;
        end
        ST_HS_DLY: begin
          if (!pwm_s)       nxt = low_path;
          else if (dly_exp) nxt = ST_HS_ON;
        end
        ST_HS_ON: begin
          if (!pwm_s) nxt = low_path;
        end
        ST_LS_WAIT: begin
          if (pwm_s)         nxt = ST_HS_WAIT;
          else if (!skip_s)  nxt = ST_IDLE;
          else if (fb_exp)   nxt = ST_LS_ON;
          else if (sw_low_s) nxt = ST_LS_DLY;
        end
        ST_LS_DLY: begin
          if (pwm_s)                  nxt = ST_HS_WAIT;
          else if (!skip_s)           nxt = ST_IDLE;
          else if (dly_exp || fb_exp) nxt = ST_LS_ON;
        end
        default: nxt = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_OFF;
    else        st <= nxt;
  end

  assign hs_en = (st == ST_HS_ON);
  assign ls_en = (st == ST_LS_ON);
endmodule

// File: rtl/hb_deadtime_ctrl.sv
module hb_deadtime_ctrl
  import hbdt_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 50_000_000,
  parameter int unsigned HS_DT_NS    = 40,
  parameter int unsigned LS_DT_NS    = 60,
  parameter int unsigned FALLBACK_NS = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwm_i,
  input  logic drv_en_i,
  input  logic uvlo_i,
  input  logic skip_n_i,
  input  logic ls_gate_low_i,
  input  logic sw_low_i,
  input  logic hs_gate_off_i,
  output logic hs_en_o,
  output logic ls_en_o
);
  localparam int unsigned HS_CYC  = ns_to_cycles(CLK_HZ, HS_DT_NS);
  localparam int unsigned LS_CYC  = ns_to_cycles(CLK_HZ, LS_DT_NS);
  localparam int unsigned FB_CYC  = ns_to_cycles(CLK_HZ, FALLBACK_NS);
  localparam int unsigned DLY_MAX = (HS_CYC > LS_CYC) ? HS_CYC : LS_CYC;
  localparam int unsigned MAX_CYC = (FB_CYC > DLY_MAX) ? FB_CYC : DLY_MAX;
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);
  localparam int unsigned N_IN    = 7;

  generate
    if (FB_CYC <= LS_CYC) begin : g_bad_cfg
      $error("fallback interval must exceed the low-side dead time");
    end
  endgenerate

  // Reset: asserted at once, released two edges later.
  logic [1:0] rst_pipe;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_int = rst_pipe[1];

  logic [N_IN-1:0] raw_in, syn_in;
  logic pwm_s, en_s, uvlo_s, skip_s, ls_low_s, sw_low_s, hs_off_s;

  assign raw_in = {pwm_i, drv_en_i, uvlo_i, skip_n_i, ls_gate_low_i, sw_low_i, hs_gate_off_i};
  assign {pwm_s, en_s, uvlo_s, skip_s, ls_low_s, sw_low_s, hs_off_s} = syn_in;

  hbdt_sync #(.W(N_IN)) u_sync (
    .clk(clk), .rst_n(rst_n_int), .d(raw_in), .q(syn_in)
  );

  hb_state_e        st;
  logic             dly_run, dly_exp, fb_run, fb_exp;
  logic [CNT_W-1:0] dly_lim;

  assign dly_run = (st == ST_HS_DLY) || (st == ST_LS_DLY);
  assign dly_lim = (st == ST_HS_DLY) ? CNT_W'(HS_CYC) : CNT_W'(LS_CYC);
  assign fb_run  = ((st == ST_LS_WAIT) || (st == ST_LS_DLY)) && hs_off_s;

  hbdt_timer #(.CNT_W(CNT_W)) u_dly_tmr (
    .clk(clk), .rst_n(rst_n_int), .run(dly_run), .limit(dly_lim), .expired(dly_exp)
  );

  hbdt_timer #(.CNT_W(CNT_W)) u_fb_tmr (
    .clk(clk), .rst_n(rst_n_int), .run(fb_run), .limit(CNT_W'(FB_CYC)), .expired(fb_exp)
  );

  hbdt_fsm u_fsm (
    .clk(clk), .rst_n(rst_n_int),
    .pwm_s(pwm_s), .en_s(en_s), .uvlo_s(uvlo_s), .skip_s(skip_s),
    .ls_low_s(ls_low_s), .sw_low_s(sw_low_s),
    .dly_exp(dly_exp), .fb_exp(fb_exp),
    .st(st), .hs_en(hs_en_o), .ls_en(ls_en_o)
  );
endmodule

// File: rtl/hbdt_chk.sv
module hbdt_chk (
  input logic clk,
  input logic rst_n,
  input logic pwm_s,
  input logic en_s,
  input logic uvlo_s,
  input logic skip_s,
  input logic hs_en,
  input logic ls_en
);
  p_no_overlap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_en && ls_en));

  p_hs_in_phase_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !pwm_s |=> !hs_en);

  p_ls_anti_phase_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pwm_s |=> !ls_en);

  p_disable_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !en_s |=> (!hs_en && !ls_en));

  p_lockout_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    uvlo_s |=> (!hs_en && !ls_en));

  p_skip_ls_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !skip_s |=> !ls_en);

  p_hs_after_ls_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_en) |-> !$past(ls_en));

  p_ls_after_hs_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_en) |-> !$past(hs_en));
endmodule

bind hb_deadtime_ctrl hbdt_chk u_chk (
  .clk(clk), .rst_n(rst_n),
  .pwm_s(pwm_s), .en_s(en_s), .uvlo_s(uvlo_s), .skip_s(skip_s),
  .hs_en(hs_en_o), .ls_en(ls_en_o)
);

// File: tb/hb_deadtime_ctrl_tb.sv
module hb_deadtime_ctrl_tb;
  // Default cycle counts: ceil(ns * 50 MHz), per the brief.
  localparam int HS_CYC = 2;
  localparam int LS_CYC = 3;
  localparam int FB_CYC = 13;
  localparam int NVEC   = 16;

  // {en, uvlo, skip_n, pwm, ls_low, sw_low, hs_off, exp_hs, exp_ls}
  localparam logic [8:0] VEC [NVEC] = '{
    9'b1_0_1_0_1_1_1_01,  // release, pwm low        R4
    9'b1_0_1_1_1_1_1_10,  // high side on            R6
    9'b1_0_1_0_1_1_1_01,  // low side on             R7
    9'b1_0_0_0_1_1_1_00,  // skip low                R5
    9'b1_0_0_1_1_1_1_10,  // skip, hs follows        R5
    9'b1_0_0_0_1_1_1_00,  // skip, pwm low           R5
    9'b1_0_1_0_1_1_1_01,  // skip released           R2
    9'b1_0_1_1_0_1_1_00,  // ls gate never low       R6
    9'b1_0_1_1_1_1_1_10,  // ls gate low sensed      R6
    9'b1_0_1_0_1_0_0_00,  // no switch/gate sense    R7
    9'b1_0_1_0_1_0_1_01,  // fallback                R8
    9'b0_0_1_1_1_1_1_00,  // disabled                R3
    9'b1_0_1_1_1_1_1_10,  // release, pwm high       R4
    9'b1_1_1_1_1_1_1_00,  // lockout                 R4
    9'b1_0_1_0_1_1_1_01,  // lockout release         R4
    9'b0_0_1_0_1_1_1_00   // disabled                R3
  };

  logic clk, rst_n;
  logic pwm, en, uvlo, skip_n, ls_low, sw_low, hs_off;
  logic hs_en, ls_en;
  int   n_chk, n_fail, n_overlap;

  hb_deadtime_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .pwm_i(pwm), .drv_en_i(en), .uvlo_i(uvlo),
    .skip_n_i(skip_n), .ls_gate_low_i(ls_low), .sw_low_i(sw_low),
    .hs_gate_off_i(hs_off), .hs_en_o(hs_en), .ls_en_o(ls_en)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // R10: watch every cycle for both enables high.
  always @(negedge clk) if (rst_n && hs_en && ls_en) n_overlap++;

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #5;
  endtask

  task automatic chk(input string req, input logic [1:0] exp);
    n_chk++;
    if ({hs_en, ls_en} !== exp) begin
      n_fail++;
      $display("FAIL %s: {hs,ls} actual=%b expected=%b at %0t", req, {hs_en, ls_en}, exp, $time);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R10: watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    n_chk = 0; n_fail = 0; n_overlap = 0;
    rst_n = 1'b0;
    {en, uvlo, skip_n, pwm, ls_low, sw_low, hs_off} = 7'b1_0_1_0_1_1_1;
    edges(4);
    chk("R3 reset", 2'b00);
    rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      {en, uvlo, skip_n, pwm, ls_low, sw_low, hs_off} = VEC[i][8:2];
      edges(25);
      chk($sformatf("R1 R2 R3 R4 R5 R8 table vec %0d", i), VEC[i][1:0]);
    end

    // Re-enable with PWM low: straight to the low side (R4).
    {en, uvlo, skip_n, pwm, ls_low, sw_low, hs_off} = 7'b1_0_1_0_0_1_0;
    edges(10);
    chk("R4 restart low", 2'b01);

    // R6: low side off first, high side waits for the low-gate sense.
    pwm = 1'b1;
    edges(3);
    chk("R6 ls off first", 2'b00);
    edges(4);
    chk("R6 waiting for ls sense", 2'b00);
    ls_low = 1'b1;
    edges(HS_CYC + 2);
    chk("R6 one edge early", 2'b00);
    edges(1);
    chk("R6 hs on", 2'b10);

    // R7 and R1: high side off three edges after PWM falls, low side waits.
    sw_low = 1'b0;
    pwm = 1'b0;
    edges(2);
    chk("R1 hs still on", 2'b10);
    edges(1);
    chk("R1 hs off", 2'b00);
    edges(5);
    chk("R7 waiting for sw sense", 2'b00);
    sw_low = 1'b1;
    edges(LS_CYC + 2);
    chk("R7 one edge early", 2'b00);
    edges(1);
    chk("R7 ls on", 2'b01);

    // R8: switch node never low, fallback from the gate-discharged sense.
    sw_low = 1'b0;
    pwm = 1'b1;
    edges(10);
    chk("R2 hs back on", 2'b10);
    pwm = 1'b0;
    edges(6);
    chk("R8 both off, no sense", 2'b00);
    hs_off = 1'b1;
    edges(FB_CYC + 1);
    chk("R8 one edge early", 2'b00);
    edges(1);
    chk("R8 fallback ls on", 2'b01);

    // R9: PWM reversed while waiting for the low-gate sense.
    hs_off = 1'b0;
    ls_low = 1'b0;
    pwm = 1'b1;
    edges(5);
    chk("R9 waiting hs", 2'b00);
    pwm = 1'b0;
    sw_low = 1'b1;
    edges(3 + LS_CYC);
    chk("R9 abandoned, ls delay running", 2'b00);
    edges(1);
    chk("R9 ls on after fresh delay", 2'b01);

    // R5: skip during a low-side wait cancels the turn-on.
    skip_n = 1'b0;
    edges(4);
    chk("R5 skip drops ls", 2'b00);

    n_chk++;
    if (n_overlap != 0) begin
      n_fail++;
      $display("FAIL R10: overlap cycles actual=%0d expected=0", n_overlap);
    end

    summary();
    $finish;
  end
endmodule